// File: doc/BRIEF.md
# Relocatable MMIO Memory Aperture Bridge

This block sits behind a 32-bit MMIO slave port and gives register-space access to a large local memory. A fixed 1 MiB hole in the 24-bit MMIO address map is mapped onto a 1 MiB window of a 40-bit memory space. A window-control register in the same MMIO map sets where that window lands. The register's base field supplies memory address bits 39:16, so the window can sit on any 64 KiB boundary.

A target field in the same register picks the destination of window accesses. Only the local-memory target is forwarded. For any other target value, the bridge answers the access itself and pulses an error flag.

Forwarded accesses go out on a request/acknowledge memory port. Only one memory transaction is pending at a time, and the MMIO side waits until that transaction finishes. All other MMIO addresses complete at once and read as zero.

Top module: `mmio_window_bridge`

## Requirements
- R1: After reset the window-control register reads 0x00000000, so the window base and the target are both zero. No memory request is pending, and the error flag is low.
- R2: An access is forwarded only when its MMIO address lies in 0x700000 to 0x7FFFFF. The window-control register answers at MMIO word address 0x001700.
- R3: A forwarded access uses the memory address `(BASE << 16) + (mmio_addr - 0x700000)`, where BASE is register bits 23:0. The result is truncated to 40 bits.
- R4: In the window-control register, bits 23:0 are the base and bits 25:24 are the target. Bits 31:26 always read 0 and ignore writes. A write updates a register byte only when its strobe bit is set. Strobe bit 3 covers the target.
- R5: Target 2'b00 is forwarded to memory. With any other target, a window read returns 0xFFFFFFFF and a window write is dropped. In both cases no memory request is made, and `mmio_err` is high for exactly the one cycle after the access completes.
- R6: For a forwarded write, the write data and all four byte strobes arrive unchanged at the memory port.
- R7: Only one memory transaction is pending at a time. `mem_req` stays high with a steady command until `mem_ack`. `mmio_ready` stays low while the request is pending and rises in the cycle after the acknowledge, carrying the returned read data.
- R8: An access outside both the window and the control register is acknowledged in the cycle it is presented. It reads as zero and changes no state.
- R9: A write to the control register applies to the very next window access.
- R10: The offset is taken from MMIO address bits 19:0 only, so the last word at 0x7FFFFC stays in the current window. The sum wraps modulo 2^40 when the base is near the top of memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmio_valid | input | 1 | MMIO access request, held until ready |
| mmio_write | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | 24 | MMIO byte address (word aligned) |
| mmio_wdata | input | 32 | MMIO write data |
| mmio_strb | input | 4 | MMIO byte strobes |
| mmio_ready | output | 1 | Access completes in this cycle |
| mmio_rdata | output | 32 | Read data, valid while ready is high |
| mmio_err | output | 1 | One-cycle pulse after a dropped window access |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_strb | output | 4 | Memory byte strobes |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with ack |

## Verification
Assertions check the timing rules on every cycle. A pending request keeps its command steady and holds off MMIO ready. Memory requests start only from decoded window accesses with the local target. A dropped access gives an error pulse and no request. Unmapped accesses complete at once with zero data. The target byte changes only under its strobe. The address arithmetic cannot be checked by these cycle-level properties, so the bench's scenarios must show it: the top-of-window offset, wrap-around at 2^40, reserved bits reading zero, base rewrites taking effect on the next access, and partial-strobe register writes.

// File: rtl/apbridge_pkg.sv
package apbridge_pkg;

    localparam int MMIO_AW   = 24;
    localparam int DATA_W    = 32;
    localparam int STRB_W    = DATA_W / 8;
    localparam int MEM_AW    = 40;
    localparam int WIN_SHIFT = 16;
    localparam int BASE_W    = MEM_AW - WIN_SHIFT;
    localparam int OFF_W     = 20;
    localparam int PAGE_W    = MMIO_AW - OFF_W;
    localparam int TGT_W     = 2;
    localparam int TGT_LSB   = BASE_W;
    localparam int TGT_BYTE  = TGT_LSB / 8;
    localparam int WORD_LSB  = 2;

    localparam logic [MMIO_AW-1:0] APER_START  = 24'h70_0000;
    localparam logic [MMIO_AW-1:0] WINREG_ADDR = 24'h00_1700;
    localparam logic [DATA_W-1:0]  DROP_RDATA  = '1;

    typedef enum logic [TGT_W-1:0] {
        TGT_LOCAL = 2'b00,
        TGT_SYS_A = 2'b01,
        TGT_SYS_B = 2'b10,
        TGT_SYS_C = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_WINREG,
        ACC_APER_MEM,
        ACC_APER_DROP
    } acc_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [BASE_W-1:0] base;
    } win_t;

    typedef struct packed {
        logic [MEM_AW-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] strb;
    } mem_cmd_t;

    function automatic logic [MEM_AW-1:0] win_translate(
        input logic [BASE_W-1:0] base,
        input logic [OFF_W-1:0]  off
    );
        return {base, {WIN_SHIFT{1'b0}}} + MEM_AW'(off);
    endfunction

    function automatic logic [DATA_W-1:0] win_pack(input win_t w);
        return DATA_W'({w.tgt, w.base});
    endfunction

endpackage

// File: rtl/apbridge_decode.sv
module apbridge_decode
    import apbridge_pkg::*;
(
    input  logic [MMIO_AW-1:0] addr,
    input  tgt_e               tgt,
    output acc_e               kind,
    output logic [OFF_W-1:0]   off
);

    localparam logic [PAGE_W-1:0] APER_PAGE = APER_START[MMIO_AW-1:OFF_W];

    always_comb begin
        off = addr[OFF_W-1:0];
        if (addr[MMIO_AW-1:OFF_W] == APER_PAGE) begin
            kind = (tgt == TGT_LOCAL) ? ACC_APER_MEM : ACC_APER_DROP;
        end else if (addr[MMIO_AW-1:WORD_LSB] == WINREG_ADDR[MMIO_AW-1:WORD_LSB]) begin
            kind = ACC_WINREG;
        end else begin
            kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/apbridge_winreg.sv
module apbridge_winreg
    import apbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output win_t              win,
    output logic [DATA_W-1:0] rd_word
);

    localparam int BASE_BYTES = BASE_W / 8;

    logic [BASE_W-1:0] base_w;
    tgt_e              tgt_q;

    for (genvar g = 0; g < BASE_BYTES; g++) begin : g_base_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (wr_en && wstrb[g]) begin
                byte_q <= wdata[g*8 +: 8];
            end
        end
        assign base_w[g*8 +: 8] = byte_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= TGT_LOCAL;
        end else if (wr_en && wstrb[TGT_BYTE]) begin
            tgt_q <= tgt_e'(wdata[TGT_LSB +: TGT_W]);
        end
    end

    always_comb begin
        win.tgt  = tgt_q;
        win.base = base_w;
        rd_word  = win_pack(win);
    end

    // R4
    tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wstrb[TGT_BYTE]) |=> $stable(tgt_q));

    // R4
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(base_w));

endmodule

// File: rtl/apbridge_seq.sv
module apbridge_seq
    import apbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mem_cmd_t          cmd_in,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_req,
    output mem_cmd_t          mem_cmd
);

    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_DONE} sq_e;

    sq_e               state_q;
    mem_cmd_t          cmd_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cmd_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start) begin
                    cmd_q   <= cmd_in;
                    state_q <= SQ_WAIT;
                end
                SQ_WAIT: if (mem_ack) begin
                    rdata_q <= mem_rdata;
                    state_q <= SQ_DONE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        idle    = (state_q == SQ_IDLE);
        done    = (state_q == SQ_DONE);
        mem_req = (state_q == SQ_WAIT);
        mem_cmd = cmd_q;
        rdata   = rdata_q;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_cmd));

    // R7
    ack_done_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req && $stable(mem_cmd));

endmodule

// File: rtl/mmio_window_bridge.sv
module mmio_window_bridge
    import apbridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mmio_valid,
    input  logic               mmio_write,
    input  logic [MMIO_AW-1:0] mmio_addr,
    input  logic [DATA_W-1:0]  mmio_wdata,
    input  logic [STRB_W-1:0]  mmio_strb,
    output logic               mmio_ready,
    output logic [DATA_W-1:0]  mmio_rdata,
    output logic               mmio_err,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [STRB_W-1:0]  mem_strb,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata
);

    win_t              win;
    logic [DATA_W-1:0] reg_word;
    acc_e              kind;
    logic [OFF_W-1:0]  off;
    mem_cmd_t          cmd_in;
    mem_cmd_t          cmd_out;
    logic              seq_idle;
    logic              seq_done;
    logic [DATA_W-1:0] seq_rdata;
    logic              seq_start;
    logic              local_ack;
    logic              reg_wr;
    logic              err_q;

    apbridge_decode u_decode (
        .addr (mmio_addr),
        .tgt  (win.tgt),
        .kind (kind),
        .off  (off)
    );

    apbridge_winreg u_winreg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wdata   (mmio_wdata),
        .wstrb   (mmio_strb),
        .win     (win),
        .rd_word (reg_word)
    );

    always_comb begin
        cmd_in.addr  = win_translate(win.base, off);
        cmd_in.we    = mmio_write;
        cmd_in.wdata = mmio_wdata;
        cmd_in.strb  = mmio_strb;
        seq_start    = seq_idle && mmio_valid && (kind == ACC_APER_MEM);
        local_ack    = seq_idle && mmio_valid && (kind != ACC_APER_MEM);
        reg_wr       = local_ack && mmio_write && (kind == ACC_WINREG);
        mmio_ready   = local_ack || seq_done;
    end

    apbridge_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (seq_start),
        .cmd_in    (cmd_in),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .idle      (seq_idle),
        .done      (seq_done),
        .rdata     (seq_rdata),
        .mem_req   (mem_req),
        .mem_cmd   (cmd_out)
    );

    always_comb begin
        mmio_rdata = '0;
        if (seq_done) begin
            mmio_rdata = seq_rdata;
        end else if (local_ack && !mmio_write) begin
            case (kind)
                ACC_WINREG:    mmio_rdata = reg_word;
                ACC_APER_DROP: mmio_rdata = DROP_RDATA;
                default:       mmio_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= local_ack && (kind == ACC_APER_DROP);
        end
    end

    always_comb begin
        mmio_err  = err_q;
        mem_we    = cmd_out.we;
        mem_addr  = cmd_out.addr;
        mem_wdata = cmd_out.wdata;
        mem_strb  = cmd_out.strb;
    end

    // R7
    no_ready_while_pending_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mmio_ready);

    // R5
    drop_err_chk: assert property (@(posedge clk) disable iff (rst)
        mmio_valid && mmio_ready && kind == ACC_APER_DROP |=> mmio_err && !mem_req);

    // R5
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        mmio_err |-> $past(mmio_valid && mmio_ready));

    // R2
    mem_issue_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(mmio_valid && kind == ACC_APER_MEM));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mmio_valid && seq_idle && kind == ACC_NONE |-> mmio_ready && mmio_rdata == '0);

endmodule

// File: tb/mmio_window_bridge_tb.sv
module mmio_window_bridge_tb;
    import apbridge_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mmio_valid = 1'b0;
    logic        mmio_write = 1'b0;
    logic [23:0] mmio_addr = '0;
    logic [31:0] mmio_wdata = '0;
    logic [3:0]  mmio_strb = '0;
    logic        mmio_ready;
    logic [31:0] mmio_rdata;
    logic        mmio_err;
    logic        mem_req;
    logic        mem_we;
    logic [39:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_strb;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_window_bridge u_dut (
        .clk(clk), .rst(rst),
        .mmio_valid(mmio_valid), .mmio_write(mmio_write), .mmio_addr(mmio_addr),
        .mmio_wdata(mmio_wdata), .mmio_strb(mmio_strb), .mmio_ready(mmio_ready),
        .mmio_rdata(mmio_rdata), .mmio_err(mmio_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_strb(mem_strb),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [39:0] a;
        logic        we;
        logic [31:0] d;
        logic [3:0]  s;
    } exp_t;

    exp_t        exp_q[$];
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;
    logic [23:0] m_base = '0;
    logic [1:0]  m_tgt = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mem_model(input logic [39:0] a);
        return a[31:0] ^ 32'h5A5A_0000 ^ {a[39:32], 24'h0};
    endfunction

    function automatic logic [39:0] exp_addr(input logic [23:0] a);
        logic [40:0] sum;
        sum = {1'b0, m_base, 16'h0} + {21'h0, a[19:0]};
        return sum[39:0];
    endfunction

    // memory responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                logic [39:0] a;
                int lat;
                bit held;
                a = mem_addr;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected memory request", {24'h0, mem_addr}, 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.a, "R3", "memory address", {24'h0, mem_addr}, {24'h0, e.a});
                    check(mem_we == e.we, "R2", "memory direction", {63'h0, mem_we}, {63'h0, e.we});
                    if (e.we) begin
                        check(mem_wdata == e.d, "R6", "write data", {32'h0, mem_wdata}, {32'h0, e.d});
                        check(mem_strb == e.s, "R6", "write strobe", {60'h0, mem_strb}, {60'h0, e.s});
                    end
                end
                lat = 1 + int'(a[3:2]);
                held = 1'b1;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!mem_req || mem_addr != a || mmio_ready) held = 1'b0;
                end
                check(held, "R7", "request held, ready low", {63'h0, held}, 64'h1);
                mem_ack   = 1'b1;
                mem_rdata = mem_model(a);
            end
        end
    end

    task automatic xfer(input bit wr, input logic [23:0] a, input logic [31:0] d,
                        input logic [3:0] s, input bit chk_rd, input logic [31:0] exp_rd,
                        input bit exp_err, input int min_w, input int max_w, input string req);
        int waits;
        logic [31:0] got;
        waits = 0;
        @(negedge clk);
        mmio_valid = 1'b1; mmio_write = wr; mmio_addr = a; mmio_wdata = d; mmio_strb = s;
        #1;
        while (!mmio_ready) begin
            @(negedge clk);
            #1;
            waits++;
        end
        got = mmio_rdata;
        @(posedge clk);
        #1;
        mmio_valid = 1'b0;
        mmio_write = 1'b0;
        @(negedge clk);
        if (chk_rd) check(got == exp_rd, req, "read data", {32'h0, got}, {32'h0, exp_rd});
        check(mmio_err == exp_err, req, "error pulse", {63'h0, mmio_err}, {63'h0, exp_err});
        check(waits >= min_w && waits <= max_w, req, "ack latency", 64'(waits), 64'(max_w));
    endtask

    task automatic reg_write(input logic [31:0] d, input logic [3:0] s);
        xfer(1'b1, 24'h001700, d, s, 1'b0, 32'h0, 1'b0, 0, 0, "R4");
        for (int b = 0; b < 3; b++) if (s[b]) m_base[b*8 +: 8] = d[b*8 +: 8];
        if (s[3]) m_tgt = d[25:24];
    endtask

    task automatic reg_read(input string req);
        xfer(1'b0, 24'h001700, 32'h0, 4'h0, 1'b1, {6'h0, m_tgt, m_base}, 1'b0, 0, 0, req);
    endtask

    task automatic ap_read(input logic [23:0] a, input string req);
        if (m_tgt != 2'b00) begin
            xfer(1'b0, a, 32'h0, 4'h0, 1'b1, 32'hFFFF_FFFF, 1'b1, 0, 0, "R5");
        end else begin
            exp_t e;
            e = '{a: exp_addr(a), we: 1'b0, d: 32'h0, s: 4'h0};
            exp_q.push_back(e);
            xfer(1'b0, a, 32'h0, 4'h0, 1'b1, mem_model(e.a), 1'b0, 3, 6, req);
        end
    endtask

    task automatic ap_write(input logic [23:0] a, input logic [31:0] d,
                            input logic [3:0] s, input string req);
        if (m_tgt != 2'b00) begin
            xfer(1'b1, a, d, s, 1'b0, 32'h0, 1'b1, 0, 0, "R5");
        end else begin
            exp_q.push_back('{a: exp_addr(a), we: 1'b1, d: d, s: s});
            xfer(1'b1, a, d, s, 1'b0, 32'h0, 1'b0, 3, 6, req);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog expired: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!mem_req && !mmio_err && !mmio_ready, "R1", "idle outputs in reset",
              {61'h0, mem_req, mmio_err, mmio_ready}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_req && !mmio_err, "R1", "idle outputs after reset",
              {62'h0, mem_req, mmio_err}, 64'h0);
        reg_read("R1");

        // R2 R3 base zero window
        ap_read(24'h700010, "R2");
        ap_write(24'h7FFFF8, 32'h1122_3344, 4'b1010, "R6");
        ap_write(24'h700004, 32'hCAFE_F00D, 4'b1111, "R6");

        // R4 reserved bits and target field
        reg_write(32'hFFFF_1234, 4'hF);
        reg_read("R4");
        ap_read(24'h700000, "R5");
        ap_write(24'h7F0000, 32'h1234_5678, 4'hF, "R5");

        // R8 unmapped space
        xfer(1'b0, 24'h000000, 32'h0, 4'h0, 1'b1, 32'h0, 1'b0, 0, 0, "R8");
        xfer(1'b1, 24'h001704, 32'hFFFF_FFFF, 4'hF, 1'b0, 32'h0, 1'b0, 0, 0, "R8");
        xfer(1'b0, 24'h001704, 32'h0, 4'h0, 1'b1, 32'h0, 1'b0, 0, 0, "R8");
        xfer(1'b0, 24'h800000, 32'h0, 4'h0, 1'b1, 32'h0, 1'b0, 0, 0, "R8");
        xfer(1'b0, 24'h6FFFFC, 32'h0, 4'h0, 1'b1, 32'h0, 1'b0, 0, 0, "R8");
        reg_read("R8");

        // R4 partial strobes
        reg_write(32'h00AB_CDEF, 4'b0011);
        reg_read("R4");
        reg_write(32'h0012_0000, 4'b0100);
        reg_write(32'h0000_0000, 4'b1000);
        reg_read("R4");

        // R9 new base applies to the next access
        ap_write(24'h7ABCD0, 32'hDEAD_BEEF, 4'b0101, "R9");
        reg_write(32'h00FF_FFFF, 4'hF);
        ap_read(24'h7FFFFC, "R10");
        reg_write(32'h0000_0010, 4'hF);
        ap_read(24'h7FFFFC, "R10");
        ap_read(24'h700000, "R9");

        for (int i = 1; i <= 5; i++) begin
            reg_write((32'(i) * 32'h0013_579B) & 32'h00FF_FFFF, 4'hF);
            ap_read(24'h700000 + 24'(i * 32'h0002_468C), "R3");
        end

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all expected memory requests seen",
              64'(exp_q.size()), 64'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule